// File: doc/BRIEF.md
# Multiplexed 4x2 Status LED Scanner

This block presents the on/off state of eight output channels on a four-row by two-column LED matrix. Only one row conducts at a time. Each row owns one quarter of the refresh frame. During its quarter the two column sources light the LEDs of the two channels that belong to that row.

An 8-bit status vector comes in, with bit k-1 standing for channel k. Four active-low row sinks and two active-high column sources go out. The length of a row slot is set in system clock cycles by the parameter `SLOT_CYCLES`. With the default value and a 50 MHz clock, a full four-row frame repeats at about 780 Hz.

Every slot opens with one blanking cycle. In that cycle all rows are released and both columns are off, and the status pair for the coming row is sampled. The columns then hold that sample until the slot ends, so the status may change at any time without disturbing the row being shown.

Top module: `led_scan_matrix`

## Requirements
- R1: Row r shows channels 2r+1 and 2r+2. Column 0 carries status bit 2r (the odd-numbered channel) and column 1 carries status bit 2r+1 (the even-numbered channel).
- R2: In every cycle at most one of the four row outputs is low.
- R3: Rows take their turn in the order 0, 1, 2, 3, 0, and so on. Each turn lasts exactly `SLOT_CYCLES` clock cycles, so every row gets one quarter of the frame. The active row's output (row_n bit r) is low in every cycle of its slot except the first.
- R4: The first cycle of every slot is blank: row_n is 4'b1111 and col is 2'b00.
- R5: The status pair is sampled only in the blank cycle. A change on the status input later in the slot does not change col before the next slot.
- R6: While rst is high, row_n is 4'b1111 and col is 2'b00. After rst falls, scanning restarts with the blank cycle of row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| status | input | 8 | Channel on/off vector; bit k-1 is channel k |
| row_n | output | 4 | Row sinks, active low, one per row |
| col | output | 2 | Column sources, active high |

## Verification
The bench sweeps all 256 status values, one full frame each, on a short slot. In every non-blank cycle it drives the inverted value onto the status input. A scanner that sampled continuously, rather than only in the blank cycle, would therefore put the inverted bits on the columns, and a swapped or shifted channel-to-row pairing would show the wrong bit for some value. Each cycle is compared against the row and phase worked out from the cycle count. This catches a slot that is one cycle too long or too short, a skipped or repeated row, a missing blanking cycle (which would cause ghosting) and two rows sinking at the same time. Reset is asserted part-way through a run to confirm that the outputs go dark and that scanning restarts with row 0 rather than resuming from where it stopped.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
    localparam int ROWS     = 4;
    localparam int COLS     = 2;
    localparam int CHANNELS = ROWS * COLS;
    localparam int ROW_W    = $clog2(ROWS);

    typedef logic [ROW_W-1:0]    row_sel_t;
    typedef logic [COLS-1:0]     col_vec_t;
    typedef logic [CHANNELS-1:0] chan_vec_t;

    // Current scan position shared by the timer, the latch and the driver.
    typedef struct packed {
        row_sel_t row;
        logic     blank;   // first cycle of a slot
        logic     wrap;    // last cycle of a slot
    } scan_pos_t;

    // Channels of row r sit in bits r*COLS .. r*COLS+COLS-1.
    function automatic col_vec_t pick_pair(input chan_vec_t st, input row_sel_t r);
        col_vec_t res;
        for (int c = 0; c < COLS; c++) begin
            res[c] = st[int'(r) * COLS + c];
        end
        return res;
    endfunction
endpackage

// File: rtl/led_slot_timer.sv
module led_slot_timer
    import led_scan_pkg::*;
#(
    parameter int SLOT_CYCLES = 16026
) (
    input  logic      clk,
    input  logic      rst,
    output scan_pos_t pos
);
    localparam int CNT_W = $clog2(SLOT_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    row_sel_t         row;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            row <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            row <= row + 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        pos.row   = row;
        pos.blank = (cnt == '0);
        pos.wrap  = (cnt == LAST);
    end

    // R3: the row advances by one, with wrap, after each slot's last cycle
    p_row_advance_r3: assert property (@(posedge clk) disable iff (rst)
        pos.wrap |=> (pos.row == row_sel_t'($past(pos.row) + 1'b1)));

    // R3: a slot's last cycle is followed by the next slot's blank cycle
    p_wrap_then_blank_r3: assert property (@(posedge clk) disable iff (rst)
        pos.wrap |=> pos.blank);

    // R3: the row stays put in the middle of a slot
    p_row_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !pos.wrap |=> $stable(pos.row));
endmodule

// File: rtl/led_pair_latch.sv
module led_pair_latch
    import led_scan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  scan_pos_t pos,
    input  chan_vec_t status,
    output col_vec_t  pair_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
        end else if (pos.blank) begin
            pair_q <= pick_pair(status, pos.row);
        end
    end

    // R5: the sampled pair is held outside the blank cycle
    p_pair_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(pos.blank) |-> $stable(pair_q));
endmodule

// File: rtl/led_row_driver.sv
module led_row_driver
    import led_scan_pkg::*;
(
    input  logic            rst,
    input  scan_pos_t       pos,
    input  col_vec_t        pair_q,
    output logic [ROWS-1:0] row_n,
    output col_vec_t        col
);
    logic lit;
    assign lit = !rst && !pos.blank;

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        assign row_n[i] = !(lit && (pos.row == row_sel_t'(i)));
    end

    assign col = lit ? pair_q : '0;
endmodule

// File: rtl/led_scan_matrix.sv
module led_scan_matrix
    import led_scan_pkg::*;
#(
    parameter int SLOT_CYCLES = 16026
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] status,
    output logic [3:0] row_n,
    output logic [1:0] col
);
    scan_pos_t pos;
    col_vec_t  pair_q;

    led_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
        .clk (clk),
        .rst (rst),
        .pos (pos)
    );

    led_pair_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .pos    (pos),
        .status (status),
        .pair_q (pair_q)
    );

    led_row_driver u_drive (
        .rst    (rst),
        .pos    (pos),
        .pair_q (pair_q),
        .row_n  (row_n),
        .col    (col)
    );

    // R2: never more than one row sinking
    p_one_row_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~row_n));

    // R4: with every row released the columns are off
    p_dark_cols_r4: assert property (@(posedge clk) disable iff (rst)
        (&row_n) |-> (col == 2'b00));

    // R6: outputs dark while reset is held
    p_reset_dark_r6: assert property (@(posedge clk)
        rst |-> ((&row_n) && (col == 2'b00)));

    // R6: the first cycle after reset is a blank cycle
    p_restart_blank_r6: assert property (@(posedge clk)
        $fell(rst) |-> (&row_n));
endmodule

// File: tb/led_scan_matrix_test.sv
module led_scan_matrix_test;
    localparam int S = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] status = 8'h00;
    logic [3:0] row_n;
    logic [1:0] col;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    led_scan_matrix #(.SLOT_CYCLES(S)) uut (
        .clk    (clk),
        .rst    (rst),
        .status (status),
        .row_n  (row_n),
        .col    (col)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a falling edge, n edges after reset release.
    task automatic scan(input int frames, input logic [7:0] salt);
        logic [1:0] expc = 2'b00;
        for (int n = 0; n < frames * 4 * S; n++) begin
            int ph = n % S;
            int r  = (n / S) % 4;
            logic [7:0] v = 8'(n / (4 * S)) ^ salt;
            chk($onehot0(~row_n), "R2", {4'h0, row_n}, 8'h0F);
            if (ph == 0) begin
                chk(row_n == 4'hF, "R4 rows", {4'h0, row_n}, 8'h0F);
                chk(col == 2'b00, "R4 cols", {6'h0, col}, 8'h00);
            end else begin
                logic [3:0] er = ~(4'b0001 << r);
                chk(row_n == er, "R3", {4'h0, row_n}, {4'h0, er});
                chk(col == expc, "R1 R5", {6'h0, col}, {6'h0, expc});
            end
            if (ph == 0) begin
                status = v;
                expc   = {v[2*r+1], v[2*r]};
            end else begin
                status = ~v;
            end
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(row_n == 4'hF, "R6 rows", {4'h0, row_n}, 8'h0F);
        chk(col == 2'b00, "R6 cols", {6'h0, col}, 8'h00);
        rst = 1'b0;
        scan(256, 8'h00);
        scan(1, 8'h5A);
        // mid-scan reset: partway into row 1
        repeat (S + 3) begin
            @(posedge clk);
            @(negedge clk);
        end
        rst = 1'b1;
        status = 8'hFF;
        repeat (4) begin
            @(posedge clk);
            @(negedge clk);
            chk(row_n == 4'hF, "R6 rows", {4'h0, row_n}, 8'h0F);
            chk(col == 2'b00, "R6 cols", {6'h0, col}, 8'h00);
        end
        rst = 1'b0;
        scan(4, 8'h3C);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule